// File: doc/BRIEF.md
# Prescaled Compare Timer

This block keeps time for software. A single up counter advances once every P+1 system clock cycles. P is a programmable prescale value. The counter runs freely and wraps from all ones back to zero.

Four compare channels watch the same counter. A channel raises its match flag when the counter steps onto the channel's compare value. Each channel drives its own interrupt line to an external interrupt controller.

Software reaches every register through a plain synchronous write port and a combinational read port. A debug-halt input can stop the time base when the control register asks for that.

Register addresses have the form {group[1:0], index}, with an index width of 2 at the default four channels:

- Group 0 holds the control register at index 0 and the counter at index 1.
- Group 1 holds the channel enables.
- Group 2 holds the compare values.
- Group 3 holds the match flags.

At the defaults this gives: control 0, counter 1, enable 4+c, compare 8+c, flag 12+c.

The control register has three fields:

- bit 0 is the timer enable.
- bit 1 is the freeze-on-debug select.
- bits 15:8 hold the prescale value P.

Top module: `cmp_timer`

## Requirements
- R1: After reset, all of these are zero: the control register, the counter, every compare value, every channel enable, every flag and every interrupt line.
- R2: With the timer enabled and prescale value P, the counter reads floor(k/(P+1)) k clock edges after the enabling write, counted from a cleared start. This holds for P = 0 (divide by 1) through P = 255 (divide by 256).
- R3: The counter wraps from 0xFFFF_FFFF to 0x0000_0000 and keeps counting.
- R4: While the enable bit is 0, the counter and the prescaler hold, and a write to address 1 loads the counter. While the enable bit is 1, a write to address 1 has no effect.
- R5: A channel sets its flag (address 12+c, bit 0) when its enable (address 4+c, bit 0) is 1 and the counter increments to the channel's compare value (address 8+c). A channel whose enable is 0 never sets its flag.
- R6: Writing 1 to bit 0 of a flag address clears that flag. Writing 0 there leaves the flag unchanged.
- R7: Each interrupt line irq[c] equals flag c AND enable c. A set flag with its enable cleared gives no interrupt but still reads back as 1.
- R8: With the freeze bit (control bit 1) set, asserting dbg_halt stops the counter. With the freeze bit clear, dbg_halt has no effect.
- R9: A control write that changes P restarts the prescaler. The next count comes exactly P_new+1 cycles after that write.
- R10: The control register and the compare registers read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address {group, index} |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| dbg_halt | input | 1 | Debug halt request |
| irq | output | 4 | Per-channel interrupt lines |

## Verification
The assertions assume wr_en is a single-cycle strobe sampled only at the rising edge. They also assume that address, data and strobe are stable around that edge, and that the addresses used match the documented map. The bench drives every write at the falling edge and releases the strobe just after the following rising edge. It changes dbg_halt only between edges and reads registers mid-cycle. As a result, every write lands on exactly one edge at a known cycle, and the expected values can be computed as edge counts.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Address groups: the top two address bits select a register group.
    typedef enum logic [1:0] {
        G_GLOBAL = 2'd0,
        G_CHEN   = 2'd1,
        G_CMP    = 2'd2,
        G_FLAG   = 2'd3
    } grp_e;

    // Index of each register inside the global group.
    localparam int IDX_CTRL  = 0;
    localparam int IDX_COUNT = 1;

    // Bit positions of the control register fields.
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_FRZ_BIT = 1;
    localparam int CTRL_PSC_LSB = 8;

    // Width of the channel index field (at least one bit).
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Control register contents.
    typedef struct packed {
        logic frz;
        logic en;
    } ctrl_bits_t;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          clr,
    input  logic [PW-1:0] psc,
    output logic          tick
);
    logic [PW-1:0] div_q;

    // One tick per psc+1 running cycles; no tick in a cycle that restarts the divider.
    assign tick = run && !clr && (div_q == psc);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= (div_q == psc) ? '0 : div_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] ld_val,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_nxt
);
    // The increment wraps naturally at the counter width.
    assign cnt_nxt = cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= ld_val;
        end else if (tick) begin
            cnt <= cnt_nxt;
        end
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_wr,
    input  logic          en_d,
    input  logic          cmp_wr,
    input  logic [CW-1:0] cmp_d,
    input  logic          clr_wr,
    input  logic          tick,
    input  logic [CW-1:0] cnt_nxt,
    output logic          en,
    output logic [CW-1:0] cmp,
    output logic          flag,
    output logic          irq
);
    logic hit;

    // A match needs the channel enabled and the counter stepping onto the compare value.
    assign hit = en && tick && (cnt_nxt == cmp);
    assign irq = flag && en;

    always_ff @(posedge clk) begin
        if (rst) begin
            en   <= 1'b0;
            cmp  <= '0;
            flag <= 1'b0;
        end else begin
            if (en_wr) begin
                en <= en_d;
            end
            if (cmp_wr) begin
                cmp <= cmp_d;
            end
            // A new match wins over a clear in the same cycle.
            if (hit) begin
                flag <= 1'b1;
            end else if (clr_wr) begin
                flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
    parameter  int NCH = 4,
    parameter  int CW  = 32,
    parameter  int PW  = 8,
    localparam int CIW = tmr_pkg::idx_w(NCH),
    localparam int AW  = CIW + 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic [CW-1:0]  wdata,
    output logic [CW-1:0]  rdata,
    input  logic           dbg_halt,
    output logic [NCH-1:0] irq
);
    import tmr_pkg::*;

    grp_e                    grp;
    logic [CIW-1:0]          idx;
    ctrl_bits_t              ctrl_q;
    logic [PW-1:0]           psc_q;
    logic                    ctrl_wr;
    logic                    cnt_ld;
    logic                    psc_chg;
    logic                    run;
    logic                    tick;
    logic [CW-1:0]           cnt_q;
    logic [CW-1:0]           cnt_nxt;
    logic [NCH-1:0]          chen_v;
    logic [NCH-1:0]          flag_v;
    logic [NCH-1:0][CW-1:0]  cmp_v;

    // Address decode.
    assign grp     = grp_e'(addr[AW-1 -: 2]);
    assign idx     = addr[CIW-1:0];
    assign ctrl_wr = wr_en && (grp == G_GLOBAL) && (idx == CIW'(IDX_CTRL));
    // Counter writes are accepted only while the timer is disabled.
    assign cnt_ld  = wr_en && (grp == G_GLOBAL) && (idx == CIW'(IDX_COUNT)) && !ctrl_q.en;
    assign psc_chg = ctrl_wr && (wdata[CTRL_PSC_LSB +: PW] != psc_q);
    assign run     = ctrl_q.en && !(ctrl_q.frz && dbg_halt);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            psc_q  <= '0;
        end else if (ctrl_wr) begin
            ctrl_q.en  <= wdata[CTRL_EN_BIT];
            ctrl_q.frz <= wdata[CTRL_FRZ_BIT];
            psc_q      <= wdata[CTRL_PSC_LSB +: PW];
        end
    end

    // Disabling the timer or changing the prescale value restarts the divider.
    tmr_prescaler #(.PW(PW)) u_psc (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .clr  (psc_chg || !ctrl_q.en),
        .psc  (psc_q),
        .tick (tick)
    );

    tmr_counter #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .load    (cnt_ld),
        .ld_val  (wdata),
        .cnt     (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    // One compare channel per index.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic sel;
        assign sel = wr_en && (idx == CIW'(c));
        tmr_channel #(.CW(CW)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .en_wr   (sel && (grp == G_CHEN)),
            .en_d    (wdata[0]),
            .cmp_wr  (sel && (grp == G_CMP)),
            .cmp_d   (wdata),
            .clr_wr  (sel && (grp == G_FLAG) && wdata[0]),
            .tick    (tick),
            .cnt_nxt (cnt_nxt),
            .en      (chen_v[c]),
            .cmp     (cmp_v[c]),
            .flag    (flag_v[c]),
            .irq     (irq[c])
        );
    end

    // Combinational read mux.
    always_comb begin
        rdata = '0;
        unique case (grp)
            G_GLOBAL: begin
                if (idx == CIW'(IDX_CTRL)) begin
                    rdata[CTRL_EN_BIT]            = ctrl_q.en;
                    rdata[CTRL_FRZ_BIT]           = ctrl_q.frz;
                    rdata[CTRL_PSC_LSB +: PW]     = psc_q;
                end else if (idx == CIW'(IDX_COUNT)) begin
                    rdata = cnt_q;
                end
            end
            G_CHEN:  rdata[0] = chen_v[idx];
            G_CMP:   rdata    = cmp_v[idx];
            G_FLAG:  rdata[0] = flag_v[idx];
            default: rdata    = '0;
        endcase
    end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int NCH = 4,
    parameter int CW  = 32,
    parameter int PW  = 8,
    parameter int CIW = 2,
    parameter int AW  = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   wr_en,
    input logic [AW-1:0]          addr,
    input logic                   wbit0,
    input logic                   en,
    input logic                   frz,
    input logic                   dbg_halt,
    input logic [PW-1:0]          psc,
    input logic                   ctrl_wr,
    input logic                   cnt_ld,
    input logic                   tick,
    input logic [CW-1:0]          cnt,
    input logic [NCH-1:0]         chen_v,
    input logic [NCH-1:0]         flag_v,
    input logic [NCH-1:0][CW-1:0] cmp_v
);
    // R2/R3: apart from a load, the counter either holds or steps by one (with wrap).
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        !cnt_ld |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

    // R2: with a divide ratio above one, ticks never come on back-to-back cycles.
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && psc != '0 && !ctrl_wr) |=> !tick);

    // R4: a disabled timer holds its count unless software loads it.
    p_hold_off_r4: assert property (@(posedge clk) disable iff (rst)
        (!en && !cnt_ld) |=> $stable(cnt));

    // R8: a frozen timer holds its count.
    p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        (en && frz && dbg_halt) |=> $stable(cnt));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        localparam logic [AW-1:0] FLAG_ADDR = AW'((3 << CIW) + c);

        // R5: a flag rises only after an enabled-channel tick that lands on the compare value.
        p_flag_cause_r5: assert property (@(posedge clk) disable iff (rst)
            $rose(flag_v[c]) |-> ($past(tick && chen_v[c]) && cnt == $past(cmp_v[c])));

        // R6: a flag falls only after a write of 1 to its address.
        p_flag_clear_r6: assert property (@(posedge clk) disable iff (rst)
            $fell(flag_v[c]) |-> $past(wr_en && addr == FLAG_ADDR && wbit0));
    end
endmodule

bind cmp_timer tmr_checker #(
    .NCH (NCH),
    .CW  (CW),
    .PW  (PW),
    .CIW (CIW),
    .AW  (AW)
) u_tmr_checker (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wbit0    (wdata[0]),
    .en       (ctrl_q.en),
    .frz      (ctrl_q.frz),
    .dbg_halt (dbg_halt),
    .psc      (psc_q),
    .ctrl_wr  (ctrl_wr),
    .cnt_ld   (cnt_ld),
    .tick     (tick),
    .cnt      (cnt_q),
    .chen_v   (chen_v),
    .flag_v   (flag_v),
    .cmp_v    (cmp_v)
);

// File: tb/tb_cmp_timer.sv
`timescale 1ns/1ps
module tb_cmp_timer;
    localparam int NCH = 4;
    localparam int CW  = 32;
    localparam int AW  = 4;
    localparam logic [AW-1:0] A_CTRL = 4'd0;
    localparam logic [AW-1:0] A_CNT  = 4'd1;
    localparam logic [AW-1:0] A_CHEN = 4'd4;
    localparam logic [AW-1:0] A_CMP  = 4'd8;
    localparam logic [AW-1:0] A_FLAG = 4'd12;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic [AW-1:0]  addr = '0;
    logic [CW-1:0]  wdata = '0;
    logic [CW-1:0]  rdata;
    logic           dbg_halt = 1'b0;
    logic [NCH-1:0] irq;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    cmp_timer dut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .dbg_halt (dbg_halt),
        .irq      (irq)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [CW-1:0] got, input logic [CW-1:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Write lands on exactly one rising edge.
    task automatic wr(input logic [AW-1:0] a, input logic [CW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    // Mid-cycle combinational read.
    task automatic rd(input logic [AW-1:0] a, output logic [CW-1:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic tick_edge;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] d;
        int plist[6] = '{0, 1, 2, 3, 5, 255};

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);

        // R1: reset state.
        rd(A_CTRL, d); check("R1 ctrl", d, 0);
        rd(A_CNT,  d); check("R1 count", d, 0);
        for (int c = 0; c < NCH; c++) begin
            rd(A_CMP + AW'(c),  d); check("R1 cmp", d, 0);
            rd(A_CHEN + AW'(c), d); check("R1 chen", d, 0);
            rd(A_FLAG + AW'(c), d); check("R1 flag", d, 0);
        end
        check("R1 irq", CW'(irq), 0);

        // R10: readback.
        wr(A_CTRL, 32'h0000_A502);
        rd(A_CTRL, d); check("R10 ctrl", d, 32'h0000_A502);
        for (int c = 0; c < NCH; c++) begin
            wr(A_CMP + AW'(c), 32'h1357_0000 + CW'(c));
            rd(A_CMP + AW'(c), d); check("R10 cmp", d, 32'h1357_0000 + CW'(c));
        end

        // R2 / R4: sweep the prescale ratio.
        foreach (plist[i]) begin
            int p;
            int n;
            p = plist[i];
            n = 3 * (p + 1) + 2;
            wr(A_CTRL, 0);
            wr(A_CNT, 0);
            rd(A_CNT, d); check("R4 load while disabled", d, 0);
            wr(A_CTRL, 32'h1 | (CW'(p) << 8));
            addr = A_CNT;
            for (int k = 1; k <= n; k++) begin
                tick_edge();
                rd(A_CNT, d);
                check("R2 divide", d, CW'(k / (p + 1)));
            end
        end

        // R4: a disabled timer holds its count.
        wr(A_CTRL, 0);
        rd(A_CNT, d);
        begin
            logic [CW-1:0] held;
            held = d;
            repeat (5) tick_edge();
            rd(A_CNT, d); check("R4 hold disabled", d, held);
        end

        // R9: a prescale change restarts the divider.
        wr(A_CTRL, 0);
        wr(A_CNT, 0);
        wr(A_CTRL, 32'h0000_0301);
        @(posedge clk);
        @(posedge clk);
        wr(A_CTRL, 32'h0000_0101);
        tick_edge(); rd(A_CNT, d); check("R9 k=1", d, 0);
        tick_edge(); rd(A_CNT, d); check("R9 k=2", d, 1);
        tick_edge(); tick_edge(); rd(A_CNT, d); check("R9 k=4", d, 2);

        // R5 / R7: compare matching, divide by 2.
        wr(A_CTRL, 0);
        wr(A_CNT, 0);
        for (int c = 0; c < NCH; c++) begin
            wr(A_CMP + AW'(c), CW'(5 + 3 * c));
            wr(A_CHEN + AW'(c), (c != 3) ? 1 : 0);
            wr(A_FLAG + AW'(c), 1);
        end
        wr(A_CTRL, 32'h0000_0101);
        for (int k = 1; k <= 32; k++) begin
            tick_edge();
            for (int c = 0; c < NCH; c++) begin
                check("R5 irq on match", CW'(irq[c]),
                      CW'((c != 3) && (k >= 2 * (5 + 3 * c))));
            end
        end
        rd(A_FLAG + 3, d); check("R5 disabled channel flag", d, 0);

        // R6: write-one-to-clear.
        wr(A_FLAG + 0, 1);
        #0.5; check("R6 clear irq0", CW'(irq[0]), 0);
        rd(A_FLAG + 0, d); check("R6 clear flag0", d, 0);
        wr(A_FLAG + 1, 0);
        rd(A_FLAG + 1, d); check("R6 write 0 keeps flag", d, 1);

        // R7: interrupt masked by the channel enable.
        wr(A_CHEN + 1, 0);
        #0.5; check("R7 masked irq1", CW'(irq[1]), 0);
        rd(A_FLAG + 1, d); check("R7 flag kept", d, 1);
        wr(A_CHEN + 1, 1);
        #0.5; check("R7 irq1 returns", CW'(irq[1]), 1);

        // R3: wrap, with a match on zero.
        wr(A_CTRL, 0);
        wr(A_CNT, 32'hFFFF_FFFE);
        wr(A_CMP + 2, 0);
        wr(A_FLAG + 2, 1);
        wr(A_CTRL, 1);
        tick_edge(); rd(A_CNT, d); check("R3 top", d, 32'hFFFF_FFFF);
        check("R3 no early match", CW'(irq[2]), 0);
        tick_edge(); rd(A_CNT, d); check("R3 wrap", d, 0);
        check("R5 match at zero", CW'(irq[2]), 1);
        tick_edge(); rd(A_CNT, d); check("R3 after wrap", d, 1);

        // R8 / R4: debug freeze; writes ignored while enabled.
        wr(A_CTRL, 0);
        wr(A_CNT, 100);
        wr(A_CTRL, 32'h3);
        repeat (3) tick_edge();
        rd(A_CNT, d); check("R8 running", d, 103);
        dbg_halt = 1'b1;
        repeat (4) tick_edge();
        rd(A_CNT, d); check("R8 frozen", d, 103);
        wr(A_CNT, 7);
        rd(A_CNT, d); check("R4 write ignored enabled", d, 103);
        wr(A_CTRL, 32'h1);
        repeat (3) tick_edge();
        rd(A_CNT, d); check("R8 no freeze select", d, 106);
        dbg_halt = 1'b0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule